// File: doc/BRIEF.md
# Cascaded Up/Down Address Counter

This block generates instruction addresses. It holds a 16-bit count in four 4-bit stages. The least significant nibble is stage 0, and each stage feeds the next. Two separate strobes move the count: one advances it and one steps it back. A parallel preset takes a full address from the load input. Each nibble passes a carry or a borrow to the next nibble in the same clock, so any step finishes in one cycle, even when it ripples through all four stages.

All controls are active-low. The decoder inverts them into one internal operation. Preset wins over any strobe. When both strobes are asserted together, the count holds.

The output is a data word plus a drive-enable flag. The flag works as a valid bit with no ready, because the block never stalls. Whenever the flag is high, a consumer must treat the word as the current address. When the flag is low, the word reads as zero. Turning the drive off has no effect on counting.

Top module: `pc_cascade`

## Requirements
- R1: With `rst` high at a rising clock edge, the count becomes 0x0000.
- R2: When `up_n`=0, `dn_n`=1 and `preset_n`=1, the count rises by one at the next rising edge.
- R3: When `dn_n`=0, `up_n`=1 and `preset_n`=1, the count falls by one at the next rising edge.
- R4: On an increment, a nibble at 0xF carries into the next nibble in the same step, so 0x0FFF becomes 0x1000 in one cycle.
- R5: On a decrement, a nibble at 0x0 borrows from the next nibble in the same step, so 0x1000 becomes 0x0FFF in one cycle.
- R6: `preset_n`=0 loads `load_addr` at the next edge, whatever the strobes are doing.
- R7: With `preset_n`=1 and both strobes at 0, the count holds.
- R8: With all three controls at 1, the count holds.
- R9: Incrementing 0xFFFF gives 0x0000, and decrementing 0x0000 gives 0xFFFF.
- R10: With `oe_n`=0, `addr_valid` is 1 and `addr_bus` shows the count in the same cycle. With `oe_n`=1, `addr_valid` is 0 and `addr_bus` is 0x0000.
- R11: The strobes keep changing the count while `oe_n`=1. The new value appears once the drive is enabled again.
- R12: 65536 consecutive increments visit every 16-bit value once and return to the start, and the same holds for decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_n | input | 1 | Increment strobe, active low |
| dn_n | input | 1 | Decrement strobe, active low |
| preset_n | input | 1 | Parallel load, active low |
| oe_n | input | 1 | Bus drive enable, active low |
| load_addr | input | 16 | Address to load on preset |
| addr_bus | output | 16 | Current address when driven, zero otherwise |
| addr_valid | output | 1 | High when the address is being driven |

## Verification
A broken carry or borrow link leaves one nibble stuck while the nibble below it wraps. The port then shows an address that is 0x10, 0x100 or 0x1000 off, and this appears at the first crossing of that nibble boundary. The full sweeps in both directions therefore expose any such fault within at most 4096 steps. A mistake in the decode priority, or in counting while the drive is off, shows one cycle after the faulty stimulus as a wrong held or loaded value. The drive-off case only becomes visible once the output is enabled again.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } pc_op_e;
endpackage

// File: rtl/pc_ctrl_decode.sv
module pc_ctrl_decode
  import pc_pkg::*;
(
  input  logic   up_n,
  input  logic   dn_n,
  input  logic   preset_n,
  output pc_op_e op_o
);
  // Active-low controls become one operation; preset has priority (R6),
  // and two strobes together cancel (R7).
  always_comb begin
    if (!preset_n)          op_o = OP_LOAD;
    else if (!up_n && dn_n) op_o = OP_INC;
    else if (up_n && !dn_n) op_o = OP_DEC;
    else                    op_o = OP_HOLD;
  end
endmodule

// File: rtl/pc_nibble_stage.sv
module pc_nibble_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o,
  output logic         carry_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + 1'b1;
    else if (dec_i)  q_o <= q_o - 1'b1;
  end

  assign carry_o  = inc_i & (q_o == TOP);
  assign borrow_o = dec_i & (q_o == '0);

  // R4: a stage that carries out rolls over to zero
  a_r4_carry_rollover: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && q_o == TOP) |=> (q_o == '0));
  // R5: a stage that borrows out rolls under to all ones
  a_r5_borrow_rollunder: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i && !inc_i && q_o == '0) |=> (q_o == TOP));
endmodule

// File: rtl/pc_cascade.sv
module pc_cascade
  import pc_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 4,
  localparam int WIDTH  = STAGE_W * STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             preset_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] load_addr,
  output logic [WIDTH-1:0] addr_bus,
  output logic             addr_valid
);
  pc_op_e           op;
  logic             do_load;
  logic [STAGES:0]  inc_chain;
  logic [STAGES:0]  dec_chain;
  logic [WIDTH-1:0] count;

  pc_ctrl_decode u_decode (
    .up_n     (up_n),
    .dn_n     (dn_n),
    .preset_n (preset_n),
    .op_o     (op)
  );

  assign do_load      = (op == OP_LOAD);
  assign inc_chain[0] = (op == OP_INC);
  assign dec_chain[0] = (op == OP_DEC);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    pc_nibble_stage #(.W(STAGE_W)) u_stage (
      .clk        (clk),
      .rst        (rst),
      .load_i     (do_load),
      .load_val_i (load_addr[g*STAGE_W +: STAGE_W]),
      .inc_i      (inc_chain[g]),
      .dec_i      (dec_chain[g]),
      .q_o        (count[g*STAGE_W +: STAGE_W]),
      .carry_o    (inc_chain[g+1]),
      .borrow_o   (dec_chain[g+1])
    );
  end

  assign addr_valid = !oe_n;
  assign addr_bus   = addr_valid ? count : '0;

  // R2: a lone up strobe steps the count by one
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (preset_n && !up_n && dn_n) |=> (count == WIDTH'($past(count) + 1'b1)));
  // R3: a lone down strobe steps the count back by one
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (preset_n && up_n && !dn_n) |=> (count == WIDTH'($past(count) - 1'b1)));
  // R6: preset wins over the strobes
  a_r6_preset_load: assert property (@(posedge clk) disable iff (rst)
    (!preset_n) |=> (count == $past(load_addr)));
  // R7: both strobes together hold
  a_r7_both_hold: assert property (@(posedge clk) disable iff (rst)
    (preset_n && !up_n && !dn_n) |=> $stable(count));
  // R8: no control asserted holds
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (preset_n && up_n && dn_n) |=> $stable(count));
  // R9: a carry out of the top stage wraps the whole count to zero
  a_r9_wrap_up: assert property (@(posedge clk) disable iff (rst)
    inc_chain[STAGES] |=> (count == '0));
  // R9: a borrow out of the top stage wraps to all ones
  a_r9_wrap_down: assert property (@(posedge clk) disable iff (rst)
    dec_chain[STAGES] |=> (count == '1));
endmodule

// File: tb/test_pc_cascade.sv
module test_pc_cascade;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_n = 1'b1;
  logic        dn_n = 1'b1;
  logic        preset_n = 1'b1;
  logic        oe_n = 1'b0;
  logic [15:0] load_addr = 16'h0000;
  logic [15:0] addr_bus;
  logic        addr_valid;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_v;

  always #4 clk = ~clk;

  pc_cascade i_pc_cascade (
    .clk(clk), .rst(rst), .up_n(up_n), .dn_n(dn_n), .preset_n(preset_n),
    .oe_n(oe_n), .load_addr(load_addr), .addr_bus(addr_bus), .addr_valid(addr_valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", addr_bus, 16'h0000);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", addr_bus, 16'h0000);
    chk("R10 valid", {15'd0, addr_valid}, 16'h0001);
    rst = 1'b0;

    // Full upward sweep: R2, R4, R9 and R12
    exp_v = 16'h0000;
    up_n = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      exp_v = exp_v + 16'h0001;
      chk("R2 up sweep", addr_bus, exp_v);
    end
    up_n = 1'b1;
    chk("R12 up returns", addr_bus, 16'h0000);

    // Full downward sweep: R3, R5, R9 and R12
    dn_n = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      exp_v = exp_v - 16'h0001;
      chk("R3 down sweep", addr_bus, exp_v);
    end
    dn_n = 1'b1;
    chk("R12 down returns", addr_bus, 16'h0000);

    // R6 preset, then R4 and R5 across a nibble boundary
    preset_n = 1'b0; load_addr = 16'h0FFF;
    @(negedge clk);
    preset_n = 1'b1;
    chk("R6 preset", addr_bus, 16'h0FFF);
    up_n = 1'b0;
    @(negedge clk);
    up_n = 1'b1;
    chk("R4 carry ripple", addr_bus, 16'h1000);
    dn_n = 1'b0;
    @(negedge clk);
    dn_n = 1'b1;
    chk("R5 borrow ripple", addr_bus, 16'h0FFF);

    // R6 priority over both strobes
    preset_n = 1'b0; up_n = 1'b0; load_addr = 16'hABCD;
    @(negedge clk);
    chk("R6 over up", addr_bus, 16'hABCD);
    up_n = 1'b1; dn_n = 1'b0; load_addr = 16'h1234;
    @(negedge clk);
    chk("R6 over down", addr_bus, 16'h1234);
    preset_n = 1'b1; dn_n = 1'b1;

    // R7: both strobes hold
    up_n = 1'b0; dn_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 both hold", addr_bus, 16'h1234);
    up_n = 1'b1; dn_n = 1'b1;

    // R8: idle hold
    repeat (3) @(negedge clk);
    chk("R8 idle hold", addr_bus, 16'h1234);

    // R10 and R11: drive off, count continues
    oe_n = 1'b1;
    #1;
    chk("R10 drive off bus", addr_bus, 16'h0000);
    chk("R10 drive off flag", {15'd0, addr_valid}, 16'h0000);
    up_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 bus stays quiet", addr_bus, 16'h0000);
    end
    up_n = 1'b1;
    oe_n = 1'b0;
    #1;
    chk("R11 counted while off", addr_bus, 16'h1239);
    chk("R10 drive on flag", {15'd0, addr_valid}, 16'h0001);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run", addr_bus, 16'h0000);

    // R9: single-step wraps both ways
    dn_n = 1'b0;
    @(negedge clk);
    dn_n = 1'b1;
    chk("R9 wrap down", addr_bus, 16'hFFFF);
    up_n = 1'b0;
    @(negedge clk);
    up_n = 1'b1;
    chk("R9 wrap up", addr_bus, 16'h0000);

    finish_run();
  end
endmodule